// File: doc/BRIEF.md
# Register-Write Command Buffer Packer

The packer turns a stream of register-write requests into a packed command buffer held in a local dword memory. Each request carries a 20-bit register offset, a 32-bit value and a mode bit.

- A direct request becomes a two-dword instruction.
- An indexed request opens a new instruction on an even dword boundary.
- A run of indexed requests to the same register folds into that one instruction. The value is appended and the instruction's count word is rewritten in place.

A commit pulse closes the buffer for an executor. The packer rounds the used size up to a whole line, zero-fills the gap one dword per cycle, and then raises a done pulse. After that pulse the buffer restarts from dword zero.

A request that cannot fit in the remaining space is not stored. It is handed out unchanged on a fallback direct-write port, and a sticky overflow flag is set until the next commit completes. The executor reads the buffer through a synchronous read port.

Top module: `cbp_packer`

## Requirements
- R1: A direct request (mode 0) at write position p stores the value at dword p and the word {8'h01, 4'hF, offset} at dword p+1. The position advances by 2, and the write position does not have to be even.
- R2: An indexed request (mode 1) that does not merge first rounds p up to an even value a. If p was odd, it zeroes dword p. It then stores the count 1 at a, the word {8'h09, 4'h0, offset} at a+1 and the value at a+2. The position becomes a+3.
- R3: An indexed request merges when the most recent instruction is indexed and its stored 20-bit offset equals the request's offset. A merge stores the value at p, rewrites that instruction's count word to its previous count plus 1, and advances p by 1.
- R4: After any indexed request, if the new position is odd and below capacity, the dword at that position is zeroed.
- R5: An indexed request never merges into a direct instruction or into an empty buffer, even when the offsets match.
- R6: A request whose dwords, alignment included, would not all fit in DEPTH_DW dwords is not stored. One cycle later fb_valid pulses with the request's offset and value, and overflow stays high from then until the next commit completes.
- R7: On commit, tail_bytes becomes the used byte count (4·p) rounded up to a multiple of LINE_BYTES. Dwords p up to tail−1 are zero-filled, and done then pulses for exactly one cycle. An empty buffer gives a tail of 0.
- R8: When done pulses, overflow is clear and the write position and last-instruction pointer are back at zero, so the next request is stored from dword 0.
- R9: busy is high from the cycle after commit until done. A request presented during busy, or in the same cycle as commit, is neither stored nor forwarded.
- R10: After reset, busy, done, overflow and fb_valid are low and tail_bytes is 0.
- R11: rd_data shows the buffer dword at rd_addr one clock after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_indexed | input | 1 | 1 = indexed write, 0 = direct write |
| req_offset | input | 20 | Register offset |
| req_value | input | 32 | Register value |
| commit | input | 1 | Close the buffer and pad it |
| busy | output | 1 | Zero-fill in progress |
| done | output | 1 | One-cycle pulse when commit completes |
| tail_bytes | output | $clog2(DEPTH_DW)+3 | Padded buffer size in bytes from the last commit |
| overflow | output | 1 | Sticky: a request was diverted |
| fb_valid | output | 1 | Fallback direct write valid |
| fb_offset | output | 20 | Fallback register offset |
| fb_value | output | 32 | Fallback register value |
| rd_addr | input | $clog2(DEPTH_DW) | Executor read address |
| rd_data | output | 32 | Executor read data |

## Verification
The hardest states to reach are near the capacity boundary, where one instruction kind still fits and another does not. Examples are an indexed request whose alignment dword pushes it one dword past the end, or a merge that lands on the last dword while its trailing pad has to be dropped. The bench reaches these states by filling a 64-dword configuration with runs of direct writes to chosen positions and then issuing each instruction kind. A sweep over every four-request mix of direct writes and indexed writes to two registers covers merging, non-merging and alignment. Requests injected during zero-fill target a dword the fill has already passed, so any wrongly accepted write would remain visible on readback.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 20;
  localparam int NPORT  = 5;   // write ports of the buffer memory

  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;
  localparam logic [3:0] BE_ALL     = 4'hF;

  typedef enum logic {ST_IDLE, ST_FILL} cbp_state_e;

  function automatic logic [DATA_W-1:0] direct_word(input logic [OFF_W-1:0] off);
    return {OP_DIRECT, BE_ALL, off};
  endfunction

  function automatic logic [DATA_W-1:0] indexed_word(input logic [OFF_W-1:0] off);
    return {OP_INDEXED, 4'h0, off};
  endfunction
endpackage

// File: rtl/cbp_emit.sv
// Turns one request into the set of dword writes it produces, plus the updated
// packing state. Purely combinational.
module cbp_emit
  import cbp_pkg::*;
#(
  parameter int DEPTH_DW = 2048,
  parameter int AW       = 11,
  parameter int PW       = 12
) (
  input  logic                         req_indexed,
  input  logic [OFF_W-1:0]             req_offset,
  input  logic [DATA_W-1:0]            req_value,
  input  logic [PW-1:0]                pos,
  input  logic [PW-1:0]                start,
  input  logic [PW-1:0]                cnt,
  input  logic [OFF_W-1:0]             last_off,
  input  logic                         last_idx,
  output logic                         fits,
  output logic [NPORT-1:0]             we,
  output logic [NPORT-1:0][AW-1:0]     waddr,
  output logic [NPORT-1:0][DATA_W-1:0] wdata,
  output logic [PW-1:0]                nxt_pos,
  output logic [PW-1:0]                nxt_start,
  output logic [PW-1:0]                nxt_cnt,
  output logic                         nxt_last_idx
);
  localparam logic [PW:0] CAP = (PW+1)'(DEPTH_DW);

  logic          merge;
  logic [PW:0]   p_ext;
  logic [PW:0]   a_ext;
  logic [AW-1:0] p_lo;
  logic [AW-1:0] a_lo;

  assign merge = req_indexed && last_idx && (last_off == req_offset);
  assign p_ext = {1'b0, pos};
  assign a_ext = p_ext + {{PW{1'b0}}, pos[0]};
  assign p_lo  = pos[AW-1:0];
  assign a_lo  = a_ext[AW-1:0];

  always_comb begin
    fits         = 1'b0;
    we           = '0;
    waddr        = '0;
    wdata        = '0;
    nxt_pos      = pos;
    nxt_start    = start;
    nxt_cnt      = cnt;
    nxt_last_idx = last_idx;
    if (!req_indexed) begin
      fits         = (p_ext + (PW+1)'(2)) <= CAP;
      we[0]        = 1'b1;
      waddr[0]     = p_lo;
      wdata[0]     = req_value;
      we[1]        = 1'b1;
      waddr[1]     = p_lo + AW'(1);
      wdata[1]     = direct_word(req_offset);
      nxt_pos      = pos + PW'(2);
      nxt_start    = pos;
      nxt_last_idx = 1'b0;
    end else if (merge) begin
      fits         = (p_ext + (PW+1)'(1)) <= CAP;
      we[0]        = 1'b1;
      waddr[0]     = p_lo;
      wdata[0]     = req_value;
      we[1]        = 1'b1;
      waddr[1]     = start[AW-1:0];
      wdata[1]     = DATA_W'(cnt + PW'(1));
      we[2]        = !pos[0] && ((p_ext + (PW+1)'(1)) < CAP);
      waddr[2]     = p_lo + AW'(1);
      nxt_pos      = pos + PW'(1);
      nxt_cnt      = cnt + PW'(1);
    end else begin
      fits         = (a_ext + (PW+1)'(3)) <= CAP;
      we[4]        = pos[0];               // alignment hole
      waddr[4]     = p_lo;
      we[0]        = 1'b1;
      waddr[0]     = a_lo;
      wdata[0]     = DATA_W'(1);
      we[1]        = 1'b1;
      waddr[1]     = a_lo + AW'(1);
      wdata[1]     = indexed_word(req_offset);
      we[2]        = 1'b1;
      waddr[2]     = a_lo + AW'(2);
      wdata[2]     = req_value;
      we[3]        = (a_ext + (PW+1)'(3)) < CAP;   // odd-end pad
      waddr[3]     = a_lo + AW'(3);
      nxt_pos      = a_ext[PW-1:0] + PW'(3);
      nxt_start    = a_ext[PW-1:0];
      nxt_cnt      = PW'(1);
      nxt_last_idx = 1'b1;
    end
  end
endmodule

// File: rtl/cbp_store.sv
// Buffer memory: several write ports applied in port order, one synchronous read.
module cbp_store
  import cbp_pkg::*;
#(
  parameter int DEPTH_DW = 2048,
  parameter int AW       = 11
) (
  input  logic                         clk,
  input  logic [NPORT-1:0]             we,
  input  logic [NPORT-1:0][AW-1:0]     waddr,
  input  logic [NPORT-1:0][DATA_W-1:0] wdata,
  input  logic [AW-1:0]                rd_addr,
  output logic [DATA_W-1:0]            rd_data
);
  logic [DATA_W-1:0] mem [DEPTH_DW];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPORT; i++) begin
      if (we[i]) mem[waddr[i]] <= wdata[i];
    end
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cbp_packer.sv
module cbp_packer
  import cbp_pkg::*;
#(
  parameter int DEPTH_DW   = 2048,
  parameter int LINE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_indexed,
  input  logic [19:0]                   req_offset,
  input  logic [31:0]                   req_value,
  input  logic                          commit,
  output logic                          busy,
  output logic                          done,
  output logic [$clog2(DEPTH_DW)+2:0]   tail_bytes,
  output logic                          overflow,
  output logic                          fb_valid,
  output logic [19:0]                   fb_offset,
  output logic [31:0]                   fb_value,
  input  logic [$clog2(DEPTH_DW)-1:0]   rd_addr,
  output logic [31:0]                   rd_data
);
  localparam int AW      = $clog2(DEPTH_DW);
  localparam int PW      = AW + 1;
  localparam int LINE_DW = LINE_BYTES / 4;
  localparam logic [PW-1:0] LINE_MASK = PW'(LINE_DW - 1);

  cbp_state_e        state_q, state_d;
  logic [PW-1:0]     pos_q, pos_d, start_q, start_d, cnt_q, cnt_d;
  logic [PW-1:0]     fill_q, fill_d, tail_q, tail_d;
  logic [OFF_W-1:0]  loff_q, loff_d;
  logic              lidx_q, lidx_d, ovf_q, ovf_d, done_q, done_d, fbv_q, fbv_d;
  logic [OFF_W-1:0]  fbo_q;
  logic [DATA_W-1:0] fbd_q;

  logic                         e_fits, e_last_idx;
  logic [NPORT-1:0]             e_we, m_we;
  logic [NPORT-1:0][AW-1:0]     e_addr, m_addr;
  logic [NPORT-1:0][DATA_W-1:0] e_data, m_data;
  logic [PW-1:0]                e_pos, e_start, e_cnt;
  logic                         accept, store, divert, kick;

  cbp_emit #(.DEPTH_DW(DEPTH_DW), .AW(AW), .PW(PW)) u_emit (
    .req_indexed (req_indexed),
    .req_offset  (req_offset),
    .req_value   (req_value),
    .pos         (pos_q),
    .start       (start_q),
    .cnt         (cnt_q),
    .last_off    (loff_q),
    .last_idx    (lidx_q),
    .fits        (e_fits),
    .we          (e_we),
    .waddr       (e_addr),
    .wdata       (e_data),
    .nxt_pos     (e_pos),
    .nxt_start   (e_start),
    .nxt_cnt     (e_cnt),
    .nxt_last_idx(e_last_idx)
  );

  cbp_store #(.DEPTH_DW(DEPTH_DW), .AW(AW)) u_store (
    .clk    (clk),
    .we     (m_we),
    .waddr  (m_addr),
    .wdata  (m_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  assign kick   = (state_q == ST_IDLE) && commit;
  assign accept = (state_q == ST_IDLE) && req_valid && !commit;
  assign store  = accept && e_fits;
  assign divert = accept && !e_fits;

  // next-state logic
  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    loff_d  = loff_q;
    lidx_d  = lidx_q;
    fill_d  = fill_q;
    tail_d  = tail_q;
    ovf_d   = ovf_q || divert;
    done_d  = 1'b0;
    fbv_d   = divert;
    m_we    = '0;
    m_addr  = e_addr;
    m_data  = e_data;
    if (store) begin
      m_we    = e_we;
      pos_d   = e_pos;
      start_d = e_start;
      cnt_d   = e_cnt;
      lidx_d  = e_last_idx;
      if (req_indexed) loff_d = req_offset;
    end
    if (kick) begin
      state_d = ST_FILL;
      fill_d  = pos_q;
      tail_d  = (pos_q + LINE_MASK) & ~LINE_MASK;
    end
    if (state_q == ST_FILL) begin
      if (fill_q != tail_q) begin
        m_we[0]   = 1'b1;
        m_addr[0] = fill_q[AW-1:0];
        m_data[0] = '0;
        fill_d    = fill_q + PW'(1);
      end else begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        pos_d   = '0;
        start_d = '0;
        cnt_d   = '0;
        lidx_d  = 1'b0;
        ovf_d   = 1'b0;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      loff_q  <= '0;
      lidx_q  <= 1'b0;
      fill_q  <= '0;
      tail_q  <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
      fbv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      loff_q  <= loff_d;
      lidx_q  <= lidx_d;
      fill_q  <= fill_d;
      tail_q  <= tail_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
      fbv_q   <= fbv_d;
    end
  end

  // fallback payload, loaded only on a diversion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbo_q <= '0;
      fbd_q <= '0;
    end else if (divert) begin
      fbo_q <= req_offset;
      fbd_q <= req_value;
    end
  end

  assign busy       = (state_q == ST_FILL);
  assign done       = done_q;
  assign tail_bytes = {tail_q, 2'b00};
  assign overflow   = ovf_q;
  assign fb_valid   = fbv_q;
  assign fb_offset  = fbo_q;
  assign fb_value   = fbd_q;
endmodule

// File: rtl/cbp_packer_chk.sv
module cbp_packer_chk #(
  parameter int DEPTH_DW   = 2048,
  parameter int LINE_BYTES = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        commit,
  input logic                        busy,
  input logic                        done,
  input logic                        overflow,
  input logic                        fb_valid,
  input logic [$clog2(DEPTH_DW)+2:0] tail_bytes
);
  localparam int TB_W = $clog2(DEPTH_DW) + 3;
  localparam logic [TB_W-1:0] LMASK = TB_W'(LINE_BYTES - 1);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  tail_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((tail_bytes & LMASK) == '0));

  // R6
  fb_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> overflow);

  // R9
  busy_no_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fb_valid);

  // R8
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!overflow && !busy));

  // R9
  commit_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && commit) |=> busy);
endmodule

bind cbp_packer cbp_packer_chk #(.DEPTH_DW(DEPTH_DW), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .commit    (commit),
  .busy      (busy),
  .done      (done),
  .overflow  (overflow),
  .fb_valid  (fb_valid),
  .tail_bytes(tail_bytes)
);

// File: tb/test_cbp_packer.sv
module test_cbp_packer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int LINE  = 64;
  localparam int LDW   = LINE / 4;

  logic        clk, rst_n;
  logic        req_valid, req_indexed, commit;
  logic [19:0] req_offset;
  logic [31:0] req_value;
  logic        busy, done, overflow, fb_valid;
  logic [8:0]  tail_bytes;
  logic [19:0] fb_offset;
  logic [31:0] fb_value;
  logic [5:0]  rd_addr;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_mem [DEPTH];
  int          m_pos, m_start, m_cnt;
  logic [19:0] m_off;
  bit          m_lidx;

  cbp_packer #(.DEPTH_DW(DEPTH), .LINE_BYTES(LINE)) i_cbp_packer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_indexed(req_indexed),
    .req_offset(req_offset), .req_value(req_value), .commit(commit),
    .busy(busy), .done(done), .tail_bytes(tail_bytes), .overflow(overflow),
    .fb_valid(fb_valid), .fb_offset(fb_offset), .fb_value(fb_value),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit idx, input logic [19:0] off, input logic [31:0] val);
    bit merge, fit;
    int a;
    merge = idx && m_lidx && (m_off == off);
    a = m_pos + (m_pos % 2);
    if (!idx)      fit = (m_pos + 2) <= DEPTH;
    else if (merge) fit = (m_pos + 1) <= DEPTH;
    else            fit = (a + 3) <= DEPTH;
    if (fit) begin
      if (!idx) begin                       // R1
        exp_mem[m_pos]     = val;
        exp_mem[m_pos + 1] = {8'h01, 4'hF, off};
        m_start = m_pos; m_pos += 2; m_lidx = 0;
      end else if (merge) begin             // R3
        exp_mem[m_pos] = val;
        m_cnt++;
        exp_mem[m_start] = m_cnt;
        m_pos += 1;
      end else begin                        // R2, R5
        if (m_pos % 2 == 1) exp_mem[m_pos] = '0;
        exp_mem[a]     = 1;
        exp_mem[a + 1] = {8'h09, 4'h0, off};
        exp_mem[a + 2] = val;
        m_start = a; m_pos = a + 3; m_cnt = 1; m_lidx = 1; m_off = off;
      end
      if (idx && (m_pos % 2 == 1) && m_pos < DEPTH) exp_mem[m_pos] = '0;  // R4
    end
    @(negedge clk);
    req_valid = 1'b1; req_indexed = idx; req_offset = off; req_value = val;
    @(negedge clk);
    req_valid = 1'b0;
    chk(fb_valid == !fit, "R6 fb_valid", 32'(fb_valid), 32'(!fit));
    if (!fit) begin
      chk(fb_offset == off, "R6 fb_offset", 32'(fb_offset), 32'(off));
      chk(fb_value == val, "R6 fb_value", fb_value, val);
      chk(overflow == 1'b1, "R6 overflow", 32'(overflow), 32'd1);
    end
  endtask

  task automatic do_commit(input bit with_req, input bit inject);
    int tail, i;
    bit seen;
    tail = ((m_pos + LDW - 1) / LDW) * LDW;
    for (int k = m_pos; k < tail; k++) exp_mem[k] = '0;
    @(negedge clk);
    commit = 1'b1;
    if (with_req) begin
      req_valid = 1'b1; req_indexed = 1'b0; req_offset = 20'h12345; req_value = 32'hDEADBEEF;
    end
    @(negedge clk);
    commit = 1'b0; req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after commit", 32'(busy), 32'd1);
    chk(fb_valid == 1'b0, "R9 request with commit ignored", 32'(fb_valid), 32'd0);
    seen = 0;
    for (i = 0; i < 300; i++) begin
      if (done) begin seen = 1; break; end
      if (inject && i == 2) begin
        req_valid = 1'b1; req_indexed = 1'b0; req_offset = 20'h00001; req_value = 32'hFFFFFFFF;
      end
      if (inject && i == 4) req_valid = 1'b0;
      if (fb_valid) chk(1'b0, "R9 request during fill forwarded", 32'd1, 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(seen, "R7 done pulse", 32'(seen), 32'd1);
    chk(tail_bytes == 9'(tail * 4), "R7 tail bytes", 32'(tail_bytes), 32'(tail * 4));
    chk(overflow == 1'b0, "R8 overflow cleared", 32'(overflow), 32'd0);
    chk(busy == 1'b0, "R9 busy low at done", 32'(busy), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", 32'(done), 32'd0);
    for (int k = 0; k < tail; k++) begin
      rd_addr = 6'(k);
      @(negedge clk);
      chk(rd_data === exp_mem[k], $sformatf("R11 R1 R2 R3 R4 R7 dword %0d", k), rd_data, exp_mem[k]);
    end
    m_pos = 0; m_start = 0; m_cnt = 0; m_lidx = 0;   // R8
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_indexed = 1'b0; req_offset = '0;
    req_value = '0; commit = 1'b0; rd_addr = '0;
    m_pos = 0; m_start = 0; m_cnt = 0; m_lidx = 0; m_off = '0;
    for (int k = 0; k < DEPTH; k++) exp_mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(busy == 1'b0, "R10 busy", 32'(busy), 32'd0);
    chk(done == 1'b0, "R10 done", 32'(done), 32'd0);
    chk(overflow == 1'b0, "R10 overflow", 32'(overflow), 32'd0);
    chk(fb_valid == 1'b0, "R10 fb_valid", 32'(fb_valid), 32'd0);
    chk(tail_bytes == '0, "R10 tail", 32'(tail_bytes), 32'd0);

    // R7: empty buffer commit gives tail 0
    do_commit(1'b0, 1'b0);

    // Sweep: all 4-request mixes of direct(A), indexed(A), indexed(B); R5 R3 R2
    for (int s = 0; s < 81; s++) begin
      int code;
      code = s;
      for (int k = 0; k < 4; k++) begin
        logic [31:0] v;
        v = {8'(s), 8'(k), 16'hA55A};
        case (code % 3)
          0:       do_req(1'b0, 20'h00000, v);
          1:       do_req(1'b1, 20'h00000, v);
          default: do_req(1'b1, 20'hABCDE, v);
        endcase
        code = code / 3;
      end
      do_commit(1'b0, 1'b0);
    end

    // Capacity edge: merge onto the last dword, then diversions (R6, R4)
    for (int k = 0; k < 30; k++) do_req(1'b0, 20'(k), 32'(k * 7));
    do_req(1'b1, 20'h0BEEF, 32'h11111111);
    do_req(1'b1, 20'h0BEEF, 32'h22222222);
    do_req(1'b1, 20'h0BEEF, 32'h33333333);
    do_req(1'b0, 20'h00042, 32'h44444444);
    do_commit(1'b0, 1'b0);

    // Indexed does not fit but a later direct still does (R6)
    for (int k = 0; k < 31; k++) do_req(1'b0, 20'(k + 100), 32'(k * 3 + 1));
    do_req(1'b1, 20'h00777, 32'h55555555);
    do_req(1'b0, 20'h00778, 32'h66666666);
    do_commit(1'b0, 1'b0);

    // Full buffer with a request presented in the commit cycle (R9)
    for (int k = 0; k < 32; k++) do_req(1'b0, 20'(k + 200), 32'(k + 9));
    do_commit(1'b1, 1'b0);

    // Request during zero-fill must leave no trace (R9), restart at 0 (R8)
    do_req(1'b0, 20'h00333, 32'hCAFEF00D);
    do_commit(1'b0, 1'b1);
    do_req(1'b0, 20'h00444, 32'h0BADBEEF);
    do_commit(1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule